// File: doc/BRIEF.md
# Lockstep Core Output Comparator

Two copies of one processor core run the same program cycle for cycle. This block sits on their outputs. It takes the whole output bundle of the primary core and of the checker core as flat vectors: bus requests, addresses, write data and strobes. On every clock it compares the two bundles. Bits that a compile-time mask marks as debug-related are left out of the compare, so debug traffic can never cause a false alarm.

Any difference in an unmasked bit produces a one-cycle error pulse on the next clock. The same pulse is sent as a fixed fault event (group 2, channel 2) to the chip's error aggregator, and it sets a sticky error bit. That bit drives a non-maskable interrupt request until software clears it with a write-one-to-clear strobe. After reset the compare stays disarmed for a set number of cycles while both cores come out of reset. A self-test input inverts one unmasked bit on the checker side, so the whole error path can be exercised on purpose.

Top module: `lockstep_cmp`

## Requirements
- R1: Every bundle bit whose mask bit is 0 is compared. A difference in any such bit, seen on a rising edge while the compare is armed, makes `cmp_err_pulse` high for the following cycle.
- R2: A bit whose mask bit (`DBG_MASK`) is 1 never causes an error, whatever its two values are.
- R3: The compare is registered. A mismatch seen on edge N shows on `cmp_err_pulse` after edge N and lasts one cycle. When the unmasked bits agree, the pulse is 0 after that edge.
- R4: `fault_valid` equals `cmp_err_pulse`. While it is 1, `fault_group` is 2 and `fault_chan` is 2. Both fields are 0 otherwise.
- R5: `cmp_err_sticky` is set by every error pulse and holds until `err_clear` is 1 on an edge that has no new mismatch. A mismatch and a clear on the same edge leave the bit set.
- R6: `nmi_req` is always equal to `cmp_err_sticky`.
- R7: When `selftest` is 1, bit `SELFTEST_BIT` of the checker bundle is inverted before the compare. Equal bundles then give an error, and bundles that differ only in that bit give none.
- R8: After reset is released, the first `SETTLE_CYCLES` rising edges raise no error, whatever the inputs are. `cmp_armed` goes to 1 on edge `SETTLE_CYCLES`, and mismatches count from the next edge on.
- R9: While reset is high, every output is 0 (`cmp_armed` too, when `SETTLE_CYCLES` > 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_bundle | input | BUNDLE_W | Output bundle of the primary core |
| chk_bundle | input | BUNDLE_W | Output bundle of the checker core |
| selftest | input | 1 | Invert one compared checker bit |
| err_clear | input | 1 | Write-one-to-clear strobe for the sticky bit |
| cmp_armed | output | 1 | Compare active (settle time is over) |
| cmp_err_pulse | output | 1 | One-cycle mismatch pulse |
| cmp_err_sticky | output | 1 | Latched compare error |
| nmi_req | output | 1 | Non-maskable interrupt request |
| fault_valid | output | 1 | Fault event strobe to the aggregator |
| fault_group | output | 3 | Fault event group code |
| fault_chan | output | 5 | Fault event channel code |

## Verification
An 8-bit bundle with a mask on bits 7 and 0 is swept over all 256 difference patterns, on two different base values. This shows whether each unmasked bit alone trips the compare and whether the masked bits, alone or together, never do. Equal bundles are run with the self-test input and without it, and so are bundles that differ only in the self-test bit. These show that the inversion lands on the right bit. Mismatches held from reset release tell apart the edges inside the settle window from the first armed edge. Clear strobes given with and without a mismatch on the same edge show which of the two wins on the sticky bit.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int unsigned GRP_W = 3;
  localparam int unsigned CHN_W = 5;

  typedef struct packed {
    logic             valid;
    logic [GRP_W-1:0] group;
    logic [CHN_W-1:0] chan;
  } fault_evt_t;
endpackage

// File: rtl/lsc_settle_timer.sv
module lsc_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  output logic armed
);
  localparam int unsigned CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES + 1);

  generate
    if (SETTLE_CYCLES == 0) begin : g_no_wait
      assign armed = 1'b1;
    end else begin : g_wait
      logic [CNT_W-1:0] cnt;
      logic             armed_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt     <= '0;
          armed_q <= 1'b0;
        end else if (!armed_q) begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(SETTLE_CYCLES - 1)) armed_q <= 1'b1;
        end
      end
      assign armed = armed_q;
    end
  endgenerate
endmodule

// File: rtl/lsc_diff_reduce.sv
module lsc_diff_reduce #(
  parameter int unsigned         W        = 64,
  parameter int unsigned         LANE_W   = 16,
  parameter logic [W-1:0]        DBG_MASK = '0,
  parameter int unsigned         ST_BIT   = 0
) (
  input  logic [W-1:0] pri,
  input  logic [W-1:0] chk,
  input  logic         selftest,
  output logic         any_diff
);
  localparam int unsigned NLANES = (W + LANE_W - 1) / LANE_W;
  localparam int unsigned PAD_W  = NLANES * LANE_W;

  logic [W-1:0]      inj;
  logic [W-1:0]      diff;
  logic [PAD_W-1:0]  diff_pad;
  logic [NLANES-1:0] lane_hit;

  always_comb begin
    inj         = '0;
    inj[ST_BIT] = selftest;
  end

  assign diff     = (pri ^ (chk ^ inj)) & ~DBG_MASK;
  assign diff_pad = PAD_W'(diff);

  generate
    for (genvar i = 0; i < NLANES; i++) begin : g_lane
      assign lane_hit[i] = |diff_pad[i*LANE_W +: LANE_W];
    end
  endgenerate

  assign any_diff = |lane_hit;
endmodule

// File: rtl/lsc_err_latch.sv
module lsc_err_latch
  import lsc_pkg::*;
#(
  parameter int unsigned FAULT_GROUP = 2,
  parameter int unsigned FAULT_CHAN  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic       clear,
  output logic       pulse,
  output logic       sticky,
  output fault_evt_t evt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= 1'b0;
      sticky <= 1'b0;
      evt    <= '0;
    end else begin
      pulse     <= hit;
      sticky    <= hit | (sticky & ~clear);
      evt.valid <= hit;
      evt.group <= hit ? GRP_W'(FAULT_GROUP) : '0;
      evt.chan  <= hit ? CHN_W'(FAULT_CHAN)  : '0;
    end
  end
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
  import lsc_pkg::*;
#(
  parameter int unsigned        BUNDLE_W      = 64,
  parameter int unsigned        LANE_W        = 16,
  parameter logic [BUNDLE_W-1:0] DBG_MASK     = 64'hFF00_0000_0000_0000,
  parameter int unsigned        SELFTEST_BIT  = 0,
  parameter int unsigned        SETTLE_CYCLES = 16,
  parameter int unsigned        FAULT_GROUP   = 2,
  parameter int unsigned        FAULT_CHAN    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BUNDLE_W-1:0] pri_bundle,
  input  logic [BUNDLE_W-1:0] chk_bundle,
  input  logic                selftest,
  input  logic                err_clear,
  output logic                cmp_armed,
  output logic                cmp_err_pulse,
  output logic                cmp_err_sticky,
  output logic                nmi_req,
  output logic                fault_valid,
  output logic [2:0]          fault_group,
  output logic [4:0]          fault_chan
);
  logic       any_diff;
  logic       armed;
  fault_evt_t evt;

  lsc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk   (clk),
    .rst   (rst),
    .armed (armed)
  );

  lsc_diff_reduce #(
    .W(BUNDLE_W), .LANE_W(LANE_W), .DBG_MASK(DBG_MASK), .ST_BIT(SELFTEST_BIT)
  ) u_diff (
    .pri      (pri_bundle),
    .chk      (chk_bundle),
    .selftest (selftest),
    .any_diff (any_diff)
  );

  lsc_err_latch #(.FAULT_GROUP(FAULT_GROUP), .FAULT_CHAN(FAULT_CHAN)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .hit    (armed & any_diff),
    .clear  (err_clear),
    .pulse  (cmp_err_pulse),
    .sticky (cmp_err_sticky),
    .evt    (evt)
  );

  assign cmp_armed   = armed;
  assign nmi_req     = cmp_err_sticky;
  assign fault_valid = evt.valid;
  assign fault_group = evt.group;
  assign fault_chan  = evt.chan;
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int unsigned         W        = 64,
  parameter logic [W-1:0]        DBG_MASK = '0,
  parameter int unsigned         ST_BIT   = 0,
  parameter int unsigned         FG       = 2,
  parameter int unsigned         FC       = 2
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] pri_bundle,
  input logic [W-1:0] chk_bundle,
  input logic         selftest,
  input logic         err_clear,
  input logic         cmp_armed,
  input logic         cmp_err_pulse,
  input logic         cmp_err_sticky,
  input logic         nmi_req,
  input logic         fault_valid,
  input logic [2:0]   fault_group,
  input logic [4:0]   fault_chan
);
  logic [W-1:0] flip;
  logic         unmasked_diff;
  always_comb begin
    flip         = '0;
    flip[ST_BIT] = selftest;
  end
  assign unmasked_diff = (((pri_bundle ^ chk_bundle ^ flip) & ~DBG_MASK) != '0);

  AST_DIFF_RAISES_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmp_armed && unmasked_diff |=> cmp_err_pulse); // R1
  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    !unmasked_diff |=> !cmp_err_pulse); // R2
  AST_EVENT_CODE: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (fault_group == 3'(FG) && fault_chan == 5'(FC) && cmp_err_pulse)); // R4
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmp_err_sticky && !err_clear |=> cmp_err_sticky); // R5
  AST_PULSE_SETS_STICKY: assert property (@(posedge clk) disable iff (rst)
    cmp_err_pulse |-> cmp_err_sticky); // R5
  AST_NMI_TRACKS: assert property (@(posedge clk) disable iff (rst)
    nmi_req == cmp_err_sticky); // R6
  AST_NO_ERR_UNARMED: assert property (@(posedge clk) disable iff (rst)
    !cmp_armed |=> !cmp_err_pulse); // R8
endmodule

bind lockstep_cmp lsc_checker #(
  .W(BUNDLE_W), .DBG_MASK(DBG_MASK), .ST_BIT(SELFTEST_BIT), .FG(FAULT_GROUP), .FC(FAULT_CHAN)
) u_lsc_chk (
  .clk(clk), .rst(rst), .pri_bundle(pri_bundle), .chk_bundle(chk_bundle),
  .selftest(selftest), .err_clear(err_clear), .cmp_armed(cmp_armed),
  .cmp_err_pulse(cmp_err_pulse), .cmp_err_sticky(cmp_err_sticky), .nmi_req(nmi_req),
  .fault_valid(fault_valid), .fault_group(fault_group), .fault_chan(fault_chan)
);

// File: tb/sim_lockstep_cmp.sv
module sim_lockstep_cmp;
  localparam int       PERIOD = 10;
  localparam int       W      = 8;
  localparam logic [7:0] MASK = 8'h81;
  localparam int       STB    = 3;
  localparam int       SETTLE = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] pri, chk;
  logic       st, clr;
  logic       armed, pulse, sticky, nmi, fv;
  logic [2:0] fg;
  logic [4:0] fc;
  int         checks = 0;
  int         fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  lockstep_cmp #(
    .BUNDLE_W(W), .LANE_W(4), .DBG_MASK(MASK), .SELFTEST_BIT(STB),
    .SETTLE_CYCLES(SETTLE), .FAULT_GROUP(2), .FAULT_CHAN(2)
  ) u0 (
    .clk(clk), .rst(rst), .pri_bundle(pri), .chk_bundle(chk), .selftest(st),
    .err_clear(clr), .cmp_armed(armed), .cmp_err_pulse(pulse), .cmp_err_sticky(sticky),
    .nmi_req(nmi), .fault_valid(fv), .fault_group(fg), .fault_chan(fc)
  );

  task automatic chk1(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [7:0] p, input logic [7:0] c, input logic s, input logic k);
    pri = p; chk = c; st = s; clr = k;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_event(input int e);
    chk1("R3 pulse", int'(pulse), e);
    chk1("R4 valid", int'(fv), e);
    chk1("R4 group", int'(fg), e ? 2 : 0);
    chk1("R4 chan", int'(fc), e ? 2 : 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; pri = 8'h00; chk = 8'hFF; st = 1'b0; clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk1("R9 armed", int'(armed), 0);
    chk1("R9 pulse", int'(pulse), 0);
    chk1("R9 sticky", int'(sticky), 0);
    chk1("R9 nmi", int'(nmi), 0);
    chk1("R9 fault", int'(fv), 0);
    rst = 1'b0;
    // R8: mismatch held from release; edges 1..SETTLE silent
    for (int e = 1; e <= SETTLE; e++) begin
      step(8'h00, 8'h3C, 1'b0, 1'b0);
      chk1("R8 no pulse in settle", int'(pulse), 0);
      chk1("R8 armed", int'(armed), (e >= SETTLE) ? 1 : 0);
    end
    step(8'h00, 8'h3C, 1'b0, 1'b0);
    chk1("R8 first armed edge pulse", int'(pulse), 1);
    chk1("R6 nmi", int'(nmi), 1);
    // R3: one-cycle pulse, R5 sticky holds
    step(8'h00, 8'h00, 1'b0, 1'b0);
    check_event(0);
    chk1("R5 sticky held", int'(sticky), 1);
    step(8'h00, 8'h00, 1'b0, 1'b1);
    chk1("R5 cleared", int'(sticky), 0);
    chk1("R6 nmi cleared", int'(nmi), 0);
    // R5: set wins over clear on same edge
    step(8'h00, 8'h10, 1'b0, 1'b1);
    chk1("R5 set beats clear", int'(sticky), 1);
    step(8'h00, 8'h00, 1'b0, 1'b1);
    // R1/R2/R3/R4: exhaustive flip sweep on two bases
    for (int b = 0; b < 2; b++) begin
      for (int f = 0; f < 256; f++) begin
        logic [7:0] base, fl;
        int e;
        base = (b == 0) ? 8'h00 : 8'hA5;
        fl   = 8'(f);
        e    = ((fl & ~MASK) != 8'h00) ? 1 : 0;
        step(base, base ^ fl, 1'b0, 1'b1);
        chk1(e ? "R1 unmasked diff" : "R2 masked only", int'(pulse), e);
        check_event(e);
        chk1("R5 sticky", int'(sticky), e);
        chk1("R6 nmi", int'(nmi), e);
      end
    end
    // R7: self-test inversion
    step(8'h5A, 8'h5A, 1'b1, 1'b1);
    chk1("R7 selftest equal bundles", int'(pulse), 1);
    step(8'h5A, 8'h5A ^ 8'(1 << STB), 1'b1, 1'b1);
    chk1("R7 selftest cancels diff", int'(pulse), 0);
    step(8'h5A, 8'h5A ^ 8'(1 << STB), 1'b0, 1'b1);
    chk1("R7 diff without selftest", int'(pulse), 1);
    step(8'h5A, 8'h5A, 1'b0, 1'b1);
    chk1("R7 idle", int'(pulse), 0);
    // R9: reset mid-run clears state
    step(8'h00, 8'hFF, 1'b0, 1'b0);
    rst = 1'b1;
    step(8'h00, 8'hFF, 1'b0, 1'b0);
    chk1("R9 sticky after reset", int'(sticky), 0);
    chk1("R9 armed after reset", int'(armed), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule